// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the word address for a four-beat memory burst. When a burst begins, the full starting address is captured. After that, each explicit advance request moves the low two bits to the next beat of the burst, and the upper bits do not change. The ordering is chosen by a mode input that is captured together with the address. In interleaved order, each beat is the starting low bits XORed with the beat number. In linear order, each beat is the starting low bits plus the beat number, modulo four. In both orders the sequence wraps inside the aligned four-word group and never carries into the upper bits.

A controller drives `load_i` when it starts an access and `adv_i` once per beat it wants to move forward. A small state machine has two states. `S_IDLE` is held from reset until the first load. `S_BURST` is held after that. The transitions are `S_IDLE -> S_BURST` on load, `S_BURST -> S_BURST` on reload, and a hold in either state otherwise. Advances have effect only in `S_BURST`. A load always takes priority over an advance in the same cycle.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is held, and after it is released, `burst_addr_o` is all zeros until the first load.
- R2: On the clock edge where `load_i` is high, `burst_addr_o` becomes `start_addr_i` exactly. This is beat 0.
- R3: Between loads, the bits of `burst_addr_o` above bit 1 keep the value captured at the last load.
- R4: With the captured mode high (interleaved), the low two bits at beat n equal the starting low bits XOR n.
- R5: With the captured mode low (linear), the low two bits at beat n equal (starting low bits + n) mod 4.
- R6: Without `load_i` or `adv_i`, `burst_addr_o` keeps its value.
- R7: After four advances the low bits return to the starting value, and the upper bits are not changed by the wrap.
- R8: An `adv_i` in the same cycle as `load_i` is ignored, so the output shows beat 0.
- R9: `mode_i` is sampled only on a load. Changing it during a burst does not change the ordering.
- R10: `adv_i` before the first load after reset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Start a burst from `start_addr_i` |
| adv_i | input | 1 | Step to the next beat |
| mode_i | input | 1 | Order: 1 interleaved, 0 linear (sampled on load) |
| start_addr_i | input | ADDR_W | Starting word address |
| burst_addr_o | output | ADDR_W | Current burst address |

## Verification
Every result is due on the rising edge that samples the stimulus. A load or an advance changes `burst_addr_o` right after that edge, through one register stage and the order logic, and a hold leaves it unchanged. The driver sets inputs on the falling edge and waits for the rising edge. It then pushes the expected address, computed by its own beat model, into a queue. The monitor pops that entry at the next falling edge, one half period after the result became valid, so every comparison sees the settled state of exactly one edge.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } order_e;

    typedef enum logic {
        S_IDLE  = 1'b0,
        S_BURST = 1'b1
    } seq_state_e;

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
    import burst_seq_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       load_i,
    input  logic       adv_i,
    output logic       capture_o,
    output logic       step_o,
    output seq_state_e state_o
);

    seq_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and command outputs
    always_comb begin
        state_d   = state_q;
        capture_o = 1'b0;
        step_o    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (load_i) begin
                    capture_o = 1'b1;
                    state_d   = S_BURST;
                end
            end
            S_BURST: begin
                if (load_i) begin
                    capture_o = 1'b1;
                end else if (adv_i) begin
                    step_o = 1'b1;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt #(
    parameter int CNT_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             step_i,
    output logic [CNT_W-1:0] beat_o
);

    logic [CNT_W-1:0] beat_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            beat_q <= '0;
        end else if (clear_i) begin
            beat_q <= '0;
        end else if (step_i) begin
            beat_q <= beat_q + CNT_W'(1);
        end
    end

    assign beat_o = beat_q;

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_seq_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  order_e           order_i,
    input  logic [CNT_W-1:0] base_i,
    input  logic [CNT_W-1:0] beat_i,
    output logic [CNT_W-1:0] offs_o
);

    logic [CNT_W-1:0] lin_w;
    logic [CNT_W-1:0] ilv_w;

    for (genvar b = 0; b < CNT_W; b++) begin : g_ilv
        assign ilv_w[b] = base_i[b] ^ beat_i[b];
    end

    assign lin_w = base_i + beat_i;

    always_comb begin
        unique case (order_i)
            ORDER_INTERLEAVED: offs_o = ilv_w;
            ORDER_LINEAR:      offs_o = lin_w;
            default:           offs_o = lin_w;
        endcase
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int CNT_W  = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic              adv_i,
    input  logic              mode_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    output logic [ADDR_W-1:0] burst_addr_o
);

    localparam int UP_W = ADDR_W - CNT_W;

    logic              capture_w;
    logic              step_w;
    seq_state_e        state_w;
    logic [CNT_W-1:0]  beat_w;
    logic [CNT_W-1:0]  offs_w;
    logic [UP_W-1:0]   upper_q;
    logic [CNT_W-1:0]  base_q;
    order_e            mode_q;
    logic              busy_w;

    burst_seq_ctrl u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (load_i),
        .adv_i     (adv_i),
        .capture_o (capture_w),
        .step_o    (step_w),
        .state_o   (state_w)
    );

    burst_beat_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (capture_w),
        .step_i  (step_w),
        .beat_o  (beat_w)
    );

    // start address and order captured at burst start
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            upper_q <= '0;
            base_q  <= '0;
            mode_q  <= ORDER_LINEAR;
        end else if (capture_w) begin
            upper_q <= start_addr_i[ADDR_W-1:CNT_W];
            base_q  <= start_addr_i[CNT_W-1:0];
            mode_q  <= order_e'(mode_i);
        end
    end

    burst_order_map #(.CNT_W(CNT_W)) u_map (
        .order_i (mode_q),
        .base_i  (base_q),
        .beat_i  (beat_w),
        .offs_o  (offs_w)
    );

    assign busy_w       = (state_w == S_BURST);
    assign burst_addr_o = {upper_q, offs_w};

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W = 19,
    parameter int CNT_W  = 2
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              load_i,
    input logic              adv_i,
    input logic [ADDR_W-1:0] start_addr_i,
    input logic [ADDR_W-1:0] burst_addr_o,
    input logic              busy,
    input logic              mode_q
);

    // R1, R10: no burst started means a zero address
    p_idle_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy |-> burst_addr_o == '0);

    p_load_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> burst_addr_o == $past(start_addr_i));

    p_upper_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> burst_addr_o[ADDR_W-1:CNT_W] == $past(burst_addr_o[ADDR_W-1:CNT_W]));

    // R4: every interleaved step flips bit 0
    p_ilv_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy && adv_i && !load_i && mode_q) |=> burst_addr_o[0] != $past(burst_addr_o[0]));

    p_lin_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy && adv_i && !load_i && !mode_q) |=>
            burst_addr_o[CNT_W-1:0] == CNT_W'($past(burst_addr_o[CNT_W-1:0]) + 1'b1));

    p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && !adv_i) |=> $stable(burst_addr_o));

    p_mode_kept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> $stable(mode_q));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load_i),
    .adv_i        (adv_i),
    .start_addr_i (start_addr_i),
    .burst_addr_o (burst_addr_o),
    .busy         (busy_w),
    .mode_q       (mode_q)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;

    localparam int ADDR_W = 19;

    typedef struct {
        logic [ADDR_W-1:0] exp;
        string             req;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load = 1'b0;
    logic              adv = 1'b0;
    logic              mode = 1'b0;
    logic [ADDR_W-1:0] start = '0;
    logic [ADDR_W-1:0] addr;

    int checks = 0;
    int errors = 0;
    item_t sb[$];

    // independent model
    logic [ADDR_W-1:0] m_start = '0;
    logic [1:0]        m_beat = '0;
    logic              m_mode = 1'b0;
    logic              m_busy = 1'b0;

    always #2 clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W)) u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .load_i       (load),
        .adv_i        (adv),
        .mode_i       (mode),
        .start_addr_i (start),
        .burst_addr_o (addr)
    );

    function automatic logic [ADDR_W-1:0] model_addr();
        logic [1:0] lo;
        if (!m_busy) return '0;
        lo = m_mode ? (m_start[1:0] ^ m_beat) : (m_start[1:0] + m_beat);
        return {m_start[ADDR_W-1:2], lo};
    endfunction

    task automatic step(input logic l, input logic a, input logic md,
                        input logic [ADDR_W-1:0] s, input string req);
        item_t it;
        @(negedge clk);
        load = l; adv = a; mode = md; start = s;
        @(posedge clk);
        if (l) begin
            m_start = s; m_mode = md; m_beat = 2'd0; m_busy = 1'b1;
        end else if (a && m_busy) begin
            m_beat = m_beat + 2'd1;
        end
        #1;
        it.exp = model_addr();
        it.req = req;
        sb.push_back(it);
    endtask

    // monitor: compare one half period after each result edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (addr !== it.exp) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", it.req, addr, it.exp);
            end
        end
    end

    initial begin
        #40000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #9;
        checks++;
        if (addr !== '0) begin
            errors++;
            $display("FAIL R1 actual=%h expected=0", addr);
        end
        #4 rst_n = 1'b1;
        // R10: advances before any load
        step(0, 1, 1, 19'h00000, "R10");
        step(0, 1, 0, 19'h00000, "R10");
        // R2, R4, R7: interleaved from ..2
        step(1, 0, 1, 19'h2A5B6, "R2");
        for (int i = 0; i < 4; i++) step(0, 1, 1, 19'h7FFFF, "R4_R7");
        // R6: hold
        step(0, 0, 0, 19'h00001, "R6");
        step(0, 0, 1, 19'h00003, "R6");
        // R8: load and advance together
        step(1, 1, 0, 19'h13573, "R8");
        // R5, R7, R3: linear from ..3 wraps without carry
        for (int i = 0; i < 4; i++) step(0, 1, 0, 19'h00000, "R5_R7_R3");
        // R9: mode toggled during an interleaved burst from ..1
        step(1, 0, 1, 19'h7FFFD, "R2");
        step(0, 1, 0, 19'h00000, "R9");
        step(0, 1, 0, 19'h00000, "R9");
        step(0, 1, 1, 19'h00000, "R9");
        // R5: linear from ..0, partial advance, then reload
        step(1, 0, 0, 19'h04440, "R2");
        step(0, 1, 1, 19'h00000, "R5");
        step(0, 0, 0, 19'h00000, "R6");
        step(0, 1, 0, 19'h00000, "R5");
        step(1, 0, 1, 19'h7FFFF, "R2");
        step(0, 1, 0, 19'h00000, "R4_R3");
        @(negedge clk); load = 0; adv = 0;
        @(negedge clk);
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule